// File: doc/BRIEF.md
# Grouped Interrupt Summary with End-of-Interrupt Re-arm

This block sits between a bank of per-pin interrupt controllers and a host processor. Every pin controller supplies a pending flag and an unmask flag. The block groups the pins four at a time. It records, for each group, whether any pin in that group is both pending and unmasked. The resulting summary vector is visible to software as two 32-bit read-only words.

The block drives one shared interrupt line to the host. The line is a single-cycle pulse. It fires when the block is armed and at least one summary bit is set, and firing disarms the block. Software services the pins it finds in the summary words. It then performs a read-modify-write of the master word that sets the end-of-interrupt (EOI) bit, which re-arms the block. If anything is still pending at that point, a fresh pulse follows at once, so no event is lost between service and re-arm. No acknowledge step is needed before the pins are serviced.

Register access uses plain strobes on a 2-bit word address: 0 is the low summary word, 1 is the high summary word, 2 is the master word, and 3 is unused.

Top module: `irq_summary_agg`

## Requirements
- R1: After reset, `host_irq` is 0, `rd_data` is 0 and the block is armed.
- R2: Summary bit n is set one clock edge after any pin in 4n..4n+3 has both `pin_pend` and `pin_unmask` high.
- R3: A pin with `pin_unmask` low sets no summary bit, whatever its pending flag.
- R4: A read is captured at the edge where `rd_en` is high and then held. Address 0 returns summary bits 31..0, and address 1 returns summary bits 45..32 in bits 13..0, with bits 31..14 reading 0.
- R5: While the block is armed, `host_irq` is high for exactly one cycle when the summary is nonzero, and the block is then disarmed.
- R6: While the block is disarmed, newly pending pins do not raise `host_irq`.
- R7: A write to address 2 with bit 16 (EOI) set re-arms the block. If the summary is nonzero, `host_irq` is high in the cycle right after the write edge.
- R8: An EOI written while the summary is zero raises no pulse. The next pin that becomes pending raises one.
- R9: The master word at address 2 always reads 0, so the EOI bit self-clears.
- R10: A master write with bit 16 clear does not re-arm the block. Writes to addresses 0 and 1 do not change the summary.
- R11: Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_pend | input | 184 | Pending flag of each pin controller |
| pin_unmask | input | 184 | Unmask flag of each pin controller |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Word address (0 low, 1 high, 2 master, 3 unused) |
| wr_data | input | 32 | Write data; bit 16 is EOI in the master word |
| rd_data | output | 32 | Registered read data |
| host_irq | output | 1 | One-cycle interrupt pulse to the host |

## Verification
The grouping is tried with single pins at the first and last slot of a group (0, 3, 4) and at the word boundary (127, 128). It is also tried at the final group (180, 183), with a masked pin, and with every pin set. Together these separate an off-by-one grouping, a swapped word and bits leaking into the padding. The pulse logic is tried with pins pending across an EOI, with no pins pending across an EOI, and with a master write whose EOI bit is clear. These cases separate a level output from a pulse, a missing re-arm from a lost re-trigger, and a decode that ignores the bit position.

// File: rtl/irq_sum_pkg.sv
package irq_sum_pkg;
  typedef enum logic [1:0] {
    ADR_STAT_LO = 2'd0,
    ADR_STAT_HI = 2'd1,
    ADR_MASTER  = 2'd2,
    ADR_SPARE   = 2'd3
  } reg_sel_e;

  // number of groups needed to cover a pin count
  function automatic int groups_for(input int pins, input int per_grp);
    return (pins + per_grp - 1) / per_grp;
  endfunction

  // mask with the low n bits set, for a 32-bit word
  function automatic logic [31:0] low_mask(input int n);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/irq_grp_or.sv
module irq_grp_or #(
  parameter int NUM_PINS = 184,
  parameter int PPG      = 4,
  parameter int NUM_GRPS = 46
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_pend,
  input  logic [NUM_PINS-1:0] pin_unmask,
  output logic [NUM_GRPS-1:0] sum_q
);
  logic [NUM_GRPS-1:0] grp_hit;

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
    logic [PPG-1:0] lane;
    for (genvar j = 0; j < PPG; j++) begin : g_lane
      if (g*PPG + j < NUM_PINS) begin : g_real
        assign lane[j] = pin_pend[g*PPG+j] & pin_unmask[g*PPG+j];
      end else begin : g_pad
        assign lane[j] = 1'b0;
      end
    end
    assign grp_hit[g] = |lane;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= grp_hit;
  end

  // R2, R3: a set summary bit traces back to an unmasked pending pin
  a_r2_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (|sum_q) |-> $past(|(pin_pend & pin_unmask)));
endmodule

// File: rtl/irq_arm_ctrl.sv
module irq_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic any_pend,
  input  logic eoi_wr,
  output logic host_irq,
  output logic armed_q
);
  assign host_irq = armed_q & any_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b1;
    else if (eoi_wr)   armed_q <= 1'b1;
    else if (host_irq) armed_q <= 1'b0;
  end

  // R5: one pulse, then disarmed unless an EOI arrived alongside
  a_r5_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && !eoi_wr) |=> !host_irq);
  // R7: after an EOI the line follows the pending summary
  a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> (host_irq == any_pend));
  // R6: a disarmed block with no EOI stays quiet in the next cycle
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !eoi_wr) |=> !host_irq);
endmodule

// File: rtl/irq_reg_read.sv
module irq_reg_read
  import irq_sum_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int NUM_GRPS = 46
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [1:0]         addr,
  input  logic [2*REG_W-1:0] status,
  output logic [REG_W-1:0]   rd_data
);
  localparam int HI_BITS = NUM_GRPS - REG_W;
  localparam logic [31:0] HI_MASK = low_mask(HI_BITS);

  logic [REG_W-1:0] rd_next;

  always_comb begin
    unique case (reg_sel_e'(addr))
      ADR_STAT_LO: rd_next = status[REG_W-1:0];
      ADR_STAT_HI: rd_next = status[2*REG_W-1:REG_W];
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  // R9: master word reads zero, EOI self-clears
  a_r9_master_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADR_MASTER) |=> (rd_data == '0));
  // R4: padding above the last group reads zero
  a_r4_hi_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADR_STAT_HI) |=> ((rd_data & ~REG_W'(HI_MASK)) == '0));
  // R4: no strobe, no change
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/irq_summary_agg.sv
module irq_summary_agg
  import irq_sum_pkg::*;
#(
  parameter int NUM_PINS = 184,
  parameter int PPG      = 4,
  parameter int REG_W    = 32,
  parameter int EOI_BIT  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_pend,
  input  logic [NUM_PINS-1:0] pin_unmask,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [1:0]          addr,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  output logic                host_irq
);
  localparam int NUM_GRPS = groups_for(NUM_PINS, PPG);
  localparam int STATUS_W = 2 * REG_W;

  logic [NUM_GRPS-1:0] sum_q;
  logic [STATUS_W-1:0] status;
  logic                any_pend;
  logic                eoi_wr;
  logic                armed_q;
  logic                unused_wdata;

  irq_grp_or #(.NUM_PINS(NUM_PINS), .PPG(PPG), .NUM_GRPS(NUM_GRPS)) u_grp (
    .clk(clk), .rst_n(rst_n), .pin_pend(pin_pend), .pin_unmask(pin_unmask),
    .sum_q(sum_q));

  for (genvar b = 0; b < STATUS_W; b++) begin : g_stat
    if (b < NUM_GRPS) begin : g_live
      assign status[b] = sum_q[b];
    end else begin : g_zero
      assign status[b] = 1'b0;
    end
  end

  assign any_pend     = |sum_q;
  assign eoi_wr       = wr_en && (addr == ADR_MASTER) && wr_data[EOI_BIT];
  assign unused_wdata = ^wr_data;

  irq_arm_ctrl u_arm (
    .clk(clk), .rst_n(rst_n), .any_pend(any_pend), .eoi_wr(eoi_wr),
    .host_irq(host_irq), .armed_q(armed_q));

  irq_reg_read #(.REG_W(REG_W), .NUM_GRPS(NUM_GRPS)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .status(status),
    .rd_data(rd_data));

  // R10: a master write without the EOI bit leaves a disarmed block disarmed
  a_r10_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && wr_en && !wr_data[EOI_BIT]) |=> !armed_q);
  // R5: the line only rises with something pending
  a_r5_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> any_pend);
endmodule

// File: tb/test_irq_summary_agg.sv
module test_irq_summary_agg;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [183:0] pin_pend = '0;
  logic [183:0] pin_unmask = '0;
  logic         rd_en = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = '0;
  logic [31:0]  wr_data = '0;
  logic [31:0]  rd_data;
  logic         host_irq;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_summary_agg i_irq_summary_agg (
    .clk(clk), .rst_n(rst_n), .pin_pend(pin_pend), .pin_unmask(pin_unmask),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .host_irq(host_irq));

  always @(negedge clk) if (host_irq) pulses++;

  // pin, unmask flag, expected group (-1 means none)
  localparam int N_VEC = 9;
  localparam int TBL_PIN [N_VEC] = '{0, 3, 4, 127, 128, 180, 183, 50, 131};
  localparam bit TBL_UNM [N_VEC] = '{1, 1, 1, 1, 1, 1, 1, 0, 1};
  localparam int TBL_GRP [N_VEC] = '{0, 0, 1, 31, 32, 45, 45, -1, 32};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; pin_pend = '0; pin_unmask = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] e;
    int p0;
    do_reset();
    @(negedge clk);
    check("R1 host_irq after reset", {31'b0, host_irq}, 32'h0);
    check("R1 rd_data after reset", rd_data, 32'h0);

    // table walk: grouping and word split
    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk);
      pin_pend = '0; pin_unmask = '0;
      pin_pend[TBL_PIN[i]] = 1'b1;
      pin_unmask[TBL_PIN[i]] = TBL_UNM[i];
      e = (TBL_GRP[i] < 0) ? 64'h0 : (64'h1 << TBL_GRP[i]);
      rd(2'd0, v); check($sformatf("R2 R3 lo pin %0d", TBL_PIN[i]), v, e[31:0]);
      rd(2'd1, v); check($sformatf("R2 R4 hi pin %0d", TBL_PIN[i]), v, e[63:32]);
    end

    // R4: every pin pending
    @(negedge clk); pin_pend = '1; pin_unmask = '1;
    rd(2'd0, v); check("R4 all lo", v, 32'hffff_ffff);
    rd(2'd1, v); check("R4 all hi", v, 32'h0000_3fff);
    // R3: all pending, all masked
    @(negedge clk); pin_unmask = '0;
    rd(2'd0, v); check("R3 all masked lo", v, 32'h0);
    rd(2'd1, v); check("R3 all masked hi", v, 32'h0);
    rd(2'd3, v); check("R11 spare reads zero", v, 32'h0);

    // R5: pulse from armed state
    do_reset();
    @(negedge clk);
    pin_pend[10] = 1'b1; pin_unmask[10] = 1'b1;
    @(negedge clk);
    check("R5 pulse high", {31'b0, host_irq}, 32'h1);
    @(negedge clk);
    check("R5 pulse one cycle", {31'b0, host_irq}, 32'h0);
    p0 = pulses;
    pin_pend[20] = 1'b1; pin_unmask[20] = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 disarmed quiet", pulses, p0);

    // R10: writes that must not act
    wr(2'd2, ~(32'h1 << 16));
    repeat (3) @(negedge clk);
    check("R10 no EOI no pulse", pulses, p0);
    wr(2'd0, 32'hffff_ffff);
    wr(2'd1, 32'hffff_ffff);
    rd(2'd0, v); check("R10 status write ignored lo", v, 32'h0000_0024);
    rd(2'd1, v); check("R10 status write ignored hi", v, 32'h0);
    check("R10 still no pulse", pulses, p0);

    // R7: EOI with pins pending re-fires at once
    wr(2'd2, 32'h1 << 16);
    check("R7 refire after EOI", {31'b0, host_irq}, 32'h1);
    @(negedge clk);
    check("R7 refire one cycle", {31'b0, host_irq}, 32'h0);
    rd(2'd2, v); check("R9 master reads zero", v, 32'h0);

    // R8: EOI with nothing pending, then a late pin
    @(negedge clk); pin_pend = '0; pin_unmask = '0;
    @(negedge clk);
    p0 = pulses;
    wr(2'd2, 32'h1 << 16);
    check("R8 EOI idle no pulse", {31'b0, host_irq}, 32'h0);
    repeat (3) @(negedge clk);
    check("R8 idle stays quiet", pulses, p0);
    pin_pend[183] = 1'b1; pin_unmask[183] = 1'b1;
    @(negedge clk);
    check("R8 late pin fires", {31'b0, host_irq}, 32'h1);
    rd(2'd2, v); check("R9 master zero again", v, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule